// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block performs 32-bit signed saturating arithmetic on two operands. A two-bit operation code picks one of four operations: add, subtract, or the same two applied after the second operand has been doubled with saturation. The first operand always stays as it is and is never doubled. Any result that would leave the signed range is clamped to the nearest limit and is not allowed to wrap.

The datapath is purely combinational, so the result is ready in the same cycle the operands are presented with the valid strobe. A valid-out strobe marks that cycle for the destination writeback. One registered flag records that saturation has happened, in either the doubling stage or the add/subtract stage. The flag stays set until an explicit clear or a reset.

Top module: `sat_arith_unit`

## Requirements
- R1: With op = 2'b00 the result is the first operand plus the second, clamped to the signed range.
- R2: With op = 2'b01 the result is the first operand minus the second, clamped to the signed range.
- R3: When op bit 1 is set, the second operand is doubled with saturation before it is added (op = 2'b10) or subtracted (op = 2'b11). The first operand is never doubled.
- R4: In the doubling stage, a second operand of 0x40000000 up to 0x7FFFFFFF becomes 0x7FFFFFFF and 0x80000000 up to 0xBFFFFFFF becomes 0x80000000. Both of these cases count as saturation. Every other value is shifted left by one, and 0xC0000000 gives 0x80000000 without counting as saturation.
- R5: When the add or subtract overflows, the result clamps to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow, and this counts as saturation.
- R6: Saturation in a cycle with in_valid high sets sat_flag at the next rising clock edge.
- R7: Saturating operands presented while in_valid is low leave sat_flag unchanged.
- R8: sat_flag is sticky. Operations never clear it. It clears on the edge where flag_clr is high and no set occurs, and when flag_clr and a set happen together, the set wins.
- R9: out_valid equals in_valid in the same cycle.
- R10: A synchronous active-low reset clears sat_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 2 | Bit 1: double the second operand; bit 0: subtract |
| opnd_a | input | 32 | First operand (signed) |
| opnd_b | input | 32 | Second operand (signed) |
| flag_clr | input | 1 | Clear the sticky saturation flag |
| result | output | 32 | Saturated result |
| out_valid | output | 1 | Result is valid for writeback |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with its default width of 32 bits. At that width the doubling thresholds 0x40000000 and 0xC0000000 and the clamp limits 0x7FFFFFFF and 0x80000000 appear as literal operand values. Each of the four operations runs on every pair drawn from the six boundary values, and a pseudo-random sweep follows. Each result and each flag update is compared with a 64-bit model.

// File: rtl/sat_pkg.sv
// Shared opcode encoding for the saturating arithmetic unit.
// Assumes a two-bit opcode in which bit 1 selects doubling and bit 0 selects subtract.
package sat_pkg;
    localparam int OP_SUB_BIT = 0;
    localparam int OP_DBL_BIT = 1;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;
endpackage

// File: rtl/sat_double.sv
// Saturating doubler. Multiplies a signed value by two and clamps it to the signed range.
// Assumes W >= 2. Purely combinational.
module sat_double #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] dbl_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    // Purpose: the two top bits disagree exactly when doubling leaves the range.
    always_comb begin
        sat_o = val_i[W-1] ^ val_i[W-2];
        if (!sat_o)
            dbl_o = {val_i[W-2:0], 1'b0};
        else if (val_i[W-1])
            dbl_o = MIN_NEG;
        else
            dbl_o = MAX_POS;
    end

    // Purpose: the doubled value always keeps the sign of its input.
    always_comb begin
        assert_dbl_sign_R4: assert (dbl_o[W-1] == val_i[W-1]);
    end
endmodule

// File: rtl/sat_addsub.sv
// Saturating signed add/subtract. Overflow is detected from the operand and result signs.
// Assumes two's complement operands of width W. Purely combinational.
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;

    // Purpose: form the wrapped result and the overflow condition from the signs.
    always_comb begin
        raw = sub_i ? (a_i - b_i) : (a_i + b_i);
        if (sub_i)
            sat_o = (a_i[W-1] != b_i[W-1]) && (raw[W-1] != a_i[W-1]);
        else
            sat_o = (a_i[W-1] == b_i[W-1]) && (raw[W-1] != a_i[W-1]);
    end

    // Purpose: clamp toward the sign of the first operand when the result overflows.
    always_comb begin
        if (!sat_o)
            res_o = raw;
        else if (a_i[W-1])
            res_o = MIN_NEG;
        else
            res_o = MAX_POS;
    end

    // Purpose: a clamped result must point the same way as the first operand.
    always_comb begin
        if (sat_o)
            assert_no_overflow_R5: assert (res_o[W-1] == a_i[W-1]);
    end
endmodule

// File: rtl/sat_sticky.sv
// Sticky flag register. A set takes priority over a clear.
// Assumes a synchronous active-low reset.
module sat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Purpose: hold the flag. It is set by events and cleared only by the explicit input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/sat_arith_unit.sv
// Top level: optional saturating doubling of the second operand, followed by a
// saturating add/subtract and a sticky saturation flag.
// Assumes that the opcode and operands are stable while in_valid is high.
module sat_arith_unit
    import sat_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] result,
    output logic             out_valid,
    output logic             sat_flag
);
    logic [WIDTH-1:0] b_dbl;
    logic [WIDTH-1:0] b_eff;
    logic             dbl_sat;
    logic             as_sat;
    logic             set_evt;

    sat_double #(.W(WIDTH)) u_dbl (
        .val_i (opnd_b),
        .dbl_o (b_dbl),
        .sat_o (dbl_sat)
    );

    // Purpose: pick the raw or the doubled second operand.
    always_comb b_eff = op[OP_DBL_BIT] ? b_dbl : opnd_b;

    sat_addsub #(.W(WIDTH)) u_as (
        .a_i   (opnd_a),
        .b_i   (b_eff),
        .sub_i (op[OP_SUB_BIT]),
        .res_o (result),
        .sat_o (as_sat)
    );

    // Purpose: combine saturation from both stages, counted only on valid cycles.
    always_comb set_evt = in_valid && ((op[OP_DBL_BIT] && dbl_sat) || as_sat);

    // Purpose: the writeback strobe follows the input strobe.
    always_comb out_valid = in_valid;

    sat_sticky u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_evt),
        .clr_i  (flag_clr),
        .flag_o (sat_flag)
    );

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flag_clr) |=> $stable(sat_flag));
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> !sat_flag);
endmodule

// File: tb/test_sat_arith_unit.sv
// Directed testbench for sat_arith_unit, with a 64-bit reference model.
module test_sat_arith_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] result;
    logic        out_valid;
    logic        sat_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sat_arith_unit #(.WIDTH(32)) i_sat_arith_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_clr(flag_clr),
        .result(result), .out_valid(out_valid), .sat_flag(sat_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: clamp a 64-bit value to the 32-bit signed range.
    function automatic longint clamp32(input longint v, output bit s);
        s = 1'b0;
        if (v > 64'sd2147483647) begin s = 1'b1; return 64'sd2147483647; end
        if (v < -64'sd2147483648) begin s = 1'b1; return -64'sd2147483648; end
        return v;
    endfunction

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] o, output logic [31:0] r, output bit s);
        longint av, bv, rv;
        bit s1, s2;
        av = longint'($signed(a));
        bv = longint'($signed(b));
        s1 = 1'b0;
        if (o[1]) bv = clamp32(bv * 2, s1);
        rv = clamp32(o[0] ? av - bv : av + bv, s2);
        r = rv[31:0];
        s = s1 | s2;
    endfunction

    // Clear the flag, apply one valid operation, then check the result and the flag.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o,
                          input string req);
        logic [31:0] er;
        bit es;
        model(a, b, o, er, es);
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b;
        #1;
        chk({req, " result"}, result, er);
        chk("R9 out_valid", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R6 flag"}, {31'b0, sat_flag}, {31'b0, es});
    endtask

    task automatic t_reset;
        chk("R10 reset flag", {31'b0, sat_flag}, 32'd0);
        chk("R9 idle out_valid", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_boundaries;
        logic [31:0] vals [6] = '{32'h3FFFFFFF, 32'h40000000, 32'hBFFFFFFF,
                                  32'hC0000000, 32'h7FFFFFFF, 32'h80000000};
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run_op(vals[i], vals[j], o[1:0], o[1] ? "R3/R4/R5" : (o[0] ? "R2/R5" : "R1/R5"));
    endtask

    task automatic t_doubling_edges;
        run_op(32'h0, 32'hC0000000, 2'b10, "R4 C0000000 no sat");
        run_op(32'h0, 32'h40000000, 2'b10, "R4 pos sat");
        run_op(32'h0, 32'h80000000, 2'b10, "R4 neg sat");
        run_op(32'h0, 32'h3FFFFFFF, 2'b11, "R4 shift");
        run_op(32'h50000000, 32'h1, 2'b10, "R3 first not doubled");
    endtask

    task automatic t_random;
        logic [31:0] s = 32'h1234ABCD;
        logic [31:0] a;
        for (int k = 0; k < 200; k++) begin
            s = s * 32'd1664525 + 32'd1013904223; a = s;
            s = s * 32'd1664525 + 32'd1013904223;
            run_op(a, s, a[3:2], "R1/R2/R3 sweep");
        end
    endtask

    task automatic t_ignore_invalid;
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0; in_valid = 1'b0;
        op = 2'b00; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h7FFFFFFF;
        #1 chk("R9 out_valid low", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R7 invalid ignored", {31'b0, sat_flag}, 32'd0);
    endtask

    task automatic t_sticky;
        run_op(32'h7FFFFFFF, 32'h1, 2'b00, "R8 setup");
        @(negedge clk); in_valid = 1'b1; op = 2'b00; opnd_a = 32'h5; opnd_b = 32'h6;
        @(negedge clk); in_valid = 1'b0;
        chk("R8 sticky after clean op", {31'b0, sat_flag}, 32'd1);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R8 clear", {31'b0, sat_flag}, 32'd0);
        flag_clr = 1'b1; in_valid = 1'b1; op = 2'b01; opnd_a = 32'h80000000; opnd_b = 32'h1;
        @(negedge clk); flag_clr = 1'b0; in_valid = 1'b0;
        chk("R8 set wins over clear", {31'b0, sat_flag}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 reset clears flag", {31'b0, sat_flag}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_doubling_edges();
        t_boundaries();
        t_ignore_invalid();
        t_sticky();
        t_random();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule